// File: doc/BRIEF.md
# Sector read sequencer

This block runs the read side of one disk sector stream. It works on recovered serial bits: each bit comes in as a one-cycle strobe and a data level. A sector mark starts a new pass through the sector. The sequencer raises the read gate partway into the leading gap, hunts for the single 1 bit that ends the sync run, and compares the serial address header against the address it was told to expect. It then waits out the data gap and hunts for the second sync bit. It assembles the data field into words, MSB first, and passes them through a two-stage buffer to a consumer that acknowledges each word. Last, it checks the 12-bit cyclic checkword stored after the data.

A header mismatch, a checkword error or a completed sector leaves the sequencer idle until the next sector mark. The checkword computed over the data is held in a status register so that software or a later stage can inspect it. A consumer that falls two words behind causes a lost-data condition. The sector still runs to its end, but it is never reported as done.

Top module: `sectorReadSeq`

## Requirements
- R1: After reset the read gate, word valid, address-mismatch, checkword-error, lost-data and sector-done outputs are all low, and the checkword status is zero.
- R2: A sector mark is acted on only while `enable` is high. It then clears the address-mismatch and checkword-error flags and restarts the field sequence at the leading gap. A sector mark with `enable` low leaves the read gate low and starts nothing.
- R3: In the leading gap the read gate goes high once GATE_ON bits have been counted since the mark. From then on the first 1 bit ends the sync, and a 1 bit seen before that point is ignored. The gate stays high until the sequencer goes idle.
- R4: The ADDR_W header bits after the sync bit are compared MSB first with `expAddr`, which is sampled at the sector mark. At the first bit that differs, `addrMismatch` goes high, the read gate drops and no data word is produced until the next mark.
- R5: After the header, a 1 bit counts as the data sync only once DATA_SYNC_START bits have been counted since the mark. Earlier 1 bits in the data gap are ignored.
- R6: The data field is DATA_WORDS words of WORD_W bits. The first bit received becomes the MSB of each word. Each word appears on `wordData` with `wordValid` high and is held unchanged until a cycle in which `wordTaken` is high.
- R7: Completed words pass through a first-stage buffer into the output stage. If a word completes while both stages are full, `lostData` is set and that word is dropped. The sector still runs through its checkword, but `sectorDone` is not raised.
- R8: At the end of the data field, `checkStatus` captures the remainder of the data polynomial times x^12 modulo x^12+x^11+x^3+x^2+x+1, computed over the data bits MSB first. The value does not change at other times.
- R9: After the 12 stored check bits, a zero remainder over data and check bits gives a one-cycle `sectorDone` pulse. A non-zero remainder sets `crcError` instead. In both cases the read gate drops.
- R10: A sector mark in the middle of a sector abandons it and restarts the sequence, so a full sector that follows completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Read operation active; sector marks are ignored while low |
| sectorMark | input | 1 | One-cycle pulse at the start of each sector |
| bitStrobe | input | 1 | One-cycle pulse for each recovered bit |
| bitIn | input | 1 | Recovered bit value, valid with `bitStrobe` |
| expAddr | input | ADDR_W | Expected header address, sampled at the sector mark |
| wordTaken | input | 1 | Consumer acknowledges the word on `wordData` |
| readGate | output | 1 | Read gate to the drive |
| wordData | output | WORD_W | Assembled data word |
| wordValid | output | 1 | `wordData` holds an unread word |
| addrMismatch | output | 1 | Header differed from `expAddr` |
| crcError | output | 1 | Checkword remainder was non-zero |
| lostData | output | 1 | A word was dropped because both buffer stages were full |
| sectorDone | output | 1 | One-cycle pulse when a sector was read cleanly |
| checkStatus | output | 12 | Checkword computed over the data field |

## Verification
The bench builds the block with GATE_ON at 6, DATA_SYNC_START at 40 and DATA_WORDS at 3, and keeps the 24-bit header and 16-bit words. A whole sector is then about a hundred bits long. The sync-search thresholds can therefore be probed with stray 1 bits on each side of them in every sector. Three words are also exactly the number needed to overflow the two buffer stages when the consumer holds off, so the lost-data path is reached in a single sector.

// File: rtl/seqPkg.sv
package seqPkg;

  localparam int CRC_W = 12;
  // x^12 + x^11 + x^3 + x^2 + x + 1, without the x^12 term
  localparam logic [CRC_W-1:0] CRC_POLY = 12'h80F;

  typedef enum logic [2:0] {
    FLD_SYNC0 = 3'b000,
    FLD_HDR   = 3'b001,
    FLD_SYNC1 = 3'b010,
    FLD_DATA  = 3'b011,
    FLD_CHK   = 3'b100,
    FLD_IDLE  = 3'b111
  } field_e;

  typedef struct packed {
    logic clrFlags;
    logic loadHdr;
    logic shiftHdr;
    logic clrCrc;
    logic shiftCrc;
    logic shiftWord;
    logic wordDone;
    logic capStatus;
  } strobe_t;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int WORD_W          = 16,
  parameter int DATA_WORDS      = 96,
  parameter int GATE_ON         = 56,
  parameter int DATA_SYNC_START = 176
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sectorMark,
  input  logic    bitStrobe,
  input  logic    bitIn,
  input  logic    hdrMiss,
  input  logic    crcNextZero,
  input  logic    lostData,
  output strobe_t stb,
  output logic    readGate,
  output logic    addrMismatch,
  output logic    crcError,
  output logic    sectorDone
);

  localparam int BC_W    = $clog2(DATA_SYNC_START + 1);
  localparam int FLD_MAX = (ADDR_W > WORD_W) ? ADDR_W : WORD_W;
  localparam int FC_W    = $clog2(FLD_MAX + 1);
  localparam int WC_W    = $clog2(DATA_WORDS + 1);
  localparam logic [BC_W-1:0] BC_MAX   = BC_W'(DATA_SYNC_START);
  localparam logic [BC_W-1:0] BC_GATE  = BC_W'(GATE_ON);
  localparam logic [FC_W-1:0] HDR_LAST = FC_W'(ADDR_W - 1);
  localparam logic [FC_W-1:0] WRD_LAST = FC_W'(WORD_W - 1);
  localparam logic [FC_W-1:0] CHK_LAST = FC_W'(CRC_W - 1);
  localparam logic [WC_W-1:0] WC_LAST  = WC_W'(DATA_WORDS - 1);

  field_e            state;
  logic [BC_W-1:0]   bitCnt;
  logic [FC_W-1:0]   fldCnt;
  logic [WC_W-1:0]   wordCnt;

  logic startMark, act, gateOk, syncOk;

  assign startMark = sectorMark & enable;
  assign act       = bitStrobe & ~startMark;
  assign gateOk    = bitCnt >= BC_GATE;
  assign syncOk    = bitCnt >= BC_MAX;

  assign readGate = ((state == FLD_SYNC0) && gateOk) ||
                    (state == FLD_HDR) || (state == FLD_SYNC1) ||
                    (state == FLD_DATA) || (state == FLD_CHK);

  always_comb begin
    stb           = '0;
    stb.clrFlags  = startMark;
    stb.loadHdr   = startMark;
    stb.clrCrc    = act & bitIn & (((state == FLD_SYNC0) & gateOk) |
                                   ((state == FLD_SYNC1) & syncOk));
    stb.shiftHdr  = act & (state == FLD_HDR);
    stb.shiftCrc  = act & ((state == FLD_HDR) | (state == FLD_DATA) |
                           (state == FLD_CHK));
    stb.shiftWord = act & (state == FLD_DATA);
    stb.wordDone  = stb.shiftWord & (fldCnt == WRD_LAST);
    stb.capStatus = stb.wordDone & (wordCnt == WC_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= FLD_IDLE;
      bitCnt       <= '0;
      fldCnt       <= '0;
      wordCnt      <= '0;
      addrMismatch <= 1'b0;
      crcError     <= 1'b0;
      sectorDone   <= 1'b0;
    end else begin
      sectorDone <= 1'b0;
      if (startMark) begin
        state        <= FLD_SYNC0;
        bitCnt       <= '0;
        fldCnt       <= '0;
        wordCnt      <= '0;
        addrMismatch <= 1'b0;
        crcError     <= 1'b0;
      end else if (bitStrobe && state != FLD_IDLE) begin
        if (bitCnt != BC_MAX) bitCnt <= bitCnt + 1'b1;
        case (state)
          FLD_SYNC0: if (gateOk && bitIn) begin
            state  <= FLD_HDR;
            fldCnt <= '0;
          end
          FLD_HDR: begin
            if (hdrMiss) begin
              addrMismatch <= 1'b1;
              state        <= FLD_IDLE;
            end else if (fldCnt == HDR_LAST) begin
              state  <= FLD_SYNC1;
              fldCnt <= '0;
            end else begin
              fldCnt <= fldCnt + 1'b1;
            end
          end
          FLD_SYNC1: if (syncOk && bitIn) begin
            state   <= FLD_DATA;
            fldCnt  <= '0;
            wordCnt <= '0;
          end
          FLD_DATA: begin
            if (fldCnt == WRD_LAST) begin
              fldCnt <= '0;
              if (wordCnt == WC_LAST) begin
                state   <= FLD_CHK;
                wordCnt <= '0;
              end else begin
                wordCnt <= wordCnt + 1'b1;
              end
            end else begin
              fldCnt <= fldCnt + 1'b1;
            end
          end
          FLD_CHK: begin
            if (fldCnt == CHK_LAST) begin
              state  <= FLD_IDLE;
              fldCnt <= '0;
              if (crcNextZero) sectorDone <= ~lostData;
              else             crcError   <= 1'b1;
            end else begin
              fldCnt <= fldCnt + 1'b1;
            end
          end
          default: state <= FLD_IDLE;
        endcase
      end
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |=> !sectorDone);
  a_r9_done_clean: assert property (@(posedge clk) disable iff (!rstN)
    sectorDone |-> (!crcError && !lostData && !addrMismatch));
  a_r4_miss_gate: assert property (@(posedge clk) disable iff (!rstN)
    addrMismatch |-> !readGate);
  a_r2_mark_clears: assert property (@(posedge clk) disable iff (!rstN)
    startMark |=> (!addrMismatch && !crcError));
  a_r9_err_gate: assert property (@(posedge clk) disable iff (!rstN)
    crcError |-> !readGate);

endmodule

// File: rtl/seqData.sv
module seqData
  import seqPkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              bitIn,
  input  logic [ADDR_W-1:0] expAddr,
  input  logic              wordTaken,
  output logic              hdrMiss,
  output logic              crcNextZero,
  output logic [WORD_W-1:0] wordData,
  output logic              wordValid,
  output logic              lostData,
  output logic [CRC_W-1:0]  checkStatus
);

  logic [ADDR_W-1:0] hdrShift;
  logic [CRC_W-1:0]  crc, crcNext;
  logic [WORD_W-1:0] wordShift, newWord, buf1;
  logic              buf1Full, buf2Full, move;

  assign hdrMiss     = bitIn ^ hdrShift[ADDR_W-1];
  assign crcNext     = {crc[CRC_W-2:0], 1'b0} ^
                       ((bitIn ^ crc[CRC_W-1]) ? CRC_POLY : '0);
  assign crcNextZero = (crcNext == '0);
  assign newWord     = {wordShift[WORD_W-2:0], bitIn};
  assign move        = buf1Full & ~buf2Full;
  assign wordValid   = buf2Full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrShift    <= '0;
      crc         <= '0;
      checkStatus <= '0;
      wordShift   <= '0;
    end else begin
      if (stb.loadHdr)       hdrShift <= expAddr;
      else if (stb.shiftHdr) hdrShift <= {hdrShift[ADDR_W-2:0], 1'b0};
      if (stb.clrCrc)        crc <= '0;
      else if (stb.shiftCrc) crc <= crcNext;
      if (stb.capStatus)     checkStatus <= crcNext;
      if (stb.shiftWord)     wordShift <= newWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      buf1     <= '0;
      buf1Full <= 1'b0;
      wordData <= '0;
      buf2Full <= 1'b0;
      lostData <= 1'b0;
    end else begin
      if (move) begin
        wordData <= buf1;
        buf2Full <= 1'b1;
      end else if (wordTaken && buf2Full) begin
        buf2Full <= 1'b0;
      end
      if (stb.wordDone) begin
        if (!buf1Full || move) begin
          buf1     <= newWord;
          buf1Full <= 1'b1;
        end else begin
          lostData <= 1'b1;
        end
      end else if (move) begin
        buf1Full <= 1'b0;
      end
      if (stb.clrFlags) lostData <= 1'b0;
    end
  end

  a_r6_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !wordTaken) |=> (wordValid && $stable(wordData)));
  a_r7_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lostData && !stb.clrFlags) |=> lostData);
  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capStatus |=> $stable(checkStatus));
  a_r7_lost_needs_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostData) |-> $past(buf1Full && buf2Full));

endmodule

// File: rtl/sectorReadSeq.sv
module sectorReadSeq
  import seqPkg::*;
#(
  parameter int ADDR_W          = 24,
  parameter int WORD_W          = 16,
  parameter int DATA_WORDS      = 96,
  parameter int GATE_ON         = 56,
  parameter int DATA_SYNC_START = 176
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              sectorMark,
  input  logic              bitStrobe,
  input  logic              bitIn,
  input  logic [ADDR_W-1:0] expAddr,
  input  logic              wordTaken,
  output logic              readGate,
  output logic [WORD_W-1:0] wordData,
  output logic              wordValid,
  output logic              addrMismatch,
  output logic              crcError,
  output logic              lostData,
  output logic              sectorDone,
  output logic [CRC_W-1:0]  checkStatus
);

  strobe_t stb;
  logic    hdrMiss, crcNextZero;

  seqCtrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS),
    .GATE_ON(GATE_ON), .DATA_SYNC_START(DATA_SYNC_START)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .sectorMark(sectorMark),
    .bitStrobe(bitStrobe), .bitIn(bitIn), .hdrMiss(hdrMiss),
    .crcNextZero(crcNextZero), .lostData(lostData), .stb(stb),
    .readGate(readGate), .addrMismatch(addrMismatch),
    .crcError(crcError), .sectorDone(sectorDone)
  );

  seqData #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .bitIn(bitIn), .expAddr(expAddr),
    .wordTaken(wordTaken), .hdrMiss(hdrMiss), .crcNextZero(crcNextZero),
    .wordData(wordData), .wordValid(wordValid), .lostData(lostData),
    .checkStatus(checkStatus)
  );

endmodule

// File: tb/sectorReadSeq_tb.sv
module sectorReadSeq_tb;

  localparam int GON = 6;
  localparam int DSS = 40;
  localparam int NW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, sectorMark = 1'b0, bitStrobe = 1'b0, bitIn = 1'b0;
  logic [23:0] expAddr = '0;
  logic wordTaken = 1'b0;
  logic readGate, wordValid, addrMismatch, crcError, lostData, sectorDone;
  logic [15:0] wordData;
  logic [11:0] checkStatus;

  int checks = 0, errors = 0, cycles = 0, doneCnt = 0;
  bit autoTake = 1'b1;
  logic [15:0] rxQ[$];
  bit sq[$];

  always #4 clk = ~clk;

  sectorReadSeq #(.GATE_ON(GON), .DATA_SYNC_START(DSS), .DATA_WORDS(NW)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .sectorMark(sectorMark),
    .bitStrobe(bitStrobe), .bitIn(bitIn), .expAddr(expAddr),
    .wordTaken(wordTaken), .readGate(readGate), .wordData(wordData),
    .wordValid(wordValid), .addrMismatch(addrMismatch), .crcError(crcError),
    .lostData(lostData), .sectorDone(sectorDone), .checkStatus(checkStatus)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Polynomial long division of (data followed by 12 zero bits).
  function automatic logic [11:0] longRem(input logic [15:0] w [NW]);
    logic [11:0] r = '0;
    logic top;
    for (int i = 0; i < NW * 16 + 12; i++) begin
      top = r[11];
      r = {r[10:0], (i < NW * 16) ? w[i / 16][15 - (i % 16)] : 1'b0};
      if (top) r = r ^ 12'h80F;
    end
    return r;
  endfunction

  // ---------------- reference model ----------------
  int mPhase = 0, mBits = 0, mCnt = 0, mWords = 0;
  logic [23:0] mAddr = '0;
  logic [15:0] mWsh = '0, mNew = '0, m1 = '0, m2 = '0;
  logic [15:0] mW [NW];
  logic [11:0] mChk = '0, eStat = '0;
  bit m1F = 0, m2F = 0, mWd = 0, mMv = 0, o1F = 0, o2F = 0;
  bit eGate = 0, eMis = 0, eErr = 0, eLost = 0, eDone = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; m1F = 0; m2F = 0; eGate = 0; eMis = 0; eErr = 0;
      eLost = 0; eDone = 0; eStat = '0; m2 = '0;
    end else begin
      mWd = 0; o1F = m1F; o2F = m2F; mMv = o1F && !o2F; eDone = 0;
      if (sectorMark && enable) begin
        mPhase = 1; mBits = 0; eMis = 0; eErr = 0; eLost = 0; mAddr = expAddr;
      end else if (bitStrobe && mPhase != 0) begin
        case (mPhase)
          1: if (mBits >= GON && bitIn) begin mPhase = 2; mCnt = 0; end
          2: begin
            if (bitIn !== mAddr[23 - mCnt]) begin eMis = 1; mPhase = 0; end
            else if (mCnt == 23) begin mPhase = 3; mCnt = 0; end
            else mCnt++;
          end
          3: if (mBits >= DSS && bitIn) begin mPhase = 4; mCnt = 0; mWords = 0; end
          4: begin
            mWsh = {mWsh[14:0], bitIn}; mCnt++;
            if (mCnt == 16) begin
              mWd = 1; mNew = mWsh; mW[mWords] = mWsh; mCnt = 0; mWords++;
              if (mWords == NW) begin mPhase = 5; eStat = longRem(mW); end
            end
          end
          default: begin
            mChk = {mChk[10:0], bitIn}; mCnt++;
            if (mCnt == 12) begin
              if (mChk != eStat) eErr = 1; else eDone = !eLost;
              mPhase = 0;
            end
          end
        endcase
        mBits++;
      end
      if (mMv) begin m2 = m1; m2F = 1; end
      else if (wordTaken && o2F) m2F = 0;
      if (mWd) begin
        if (!o1F || mMv) begin m1 = mNew; m1F = 1; end
        else eLost = 1;
      end else if (mMv) m1F = 0;
      eGate = (mPhase == 1 && mBits >= GON) || (mPhase >= 2);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(readGate == eGate, "R3 readGate", readGate, eGate);
      check(wordValid == m2F, "R6 wordValid", wordValid, m2F);
      if (m2F) check(wordData == m2, "R6 wordData", wordData, m2);
      check(addrMismatch == eMis, "R4 addrMismatch", addrMismatch, eMis);
      check(crcError == eErr, "R9 crcError", crcError, eErr);
      check(lostData == eLost, "R7 lostData", lostData, eLost);
      check(sectorDone == eDone, "R9 sectorDone", sectorDone, eDone);
      check(checkStatus == eStat, "R8 checkStatus", checkStatus, eStat);
    end
    wordTaken = autoTake && wordValid;
  end

  always @(posedge clk) begin
    cycles++;
    if (rstN && wordValid && wordTaken) rxQ.push_back(wordData);
    if (rstN && sectorDone) doneCnt++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulseMark();
    @(negedge clk); sectorMark = 1'b1;
    @(negedge clk); sectorMark = 1'b0;
  endtask

  task automatic sendBit(input bit b);
    @(negedge clk); bitStrobe = 1'b1; bitIn = b;
    @(negedge clk); bitStrobe = 1'b0; bitIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic buildSector(input logic [23:0] a, input logic [15:0] w0,
                             input logic [15:0] w1, input logic [15:0] w2,
                             input bit corrupt);
    logic [15:0] w [NW];
    logic [11:0] r;
    w[0] = w0; w[1] = w1; w[2] = w2;
    sq.delete();
    for (int i = 0; i < 10; i++) sq.push_back(i == 2);   // stray 1 before gate
    sq.push_back(1'b1);                                  // sync at bit 10
    for (int i = 23; i >= 0; i--) sq.push_back(a[i]);    // bits 11..34
    for (int i = 35; i < 44; i++) sq.push_back(i == 37); // stray 1 before DSS
    sq.push_back(1'b1);                                  // data sync at 44
    for (int k = 0; k < NW; k++)
      for (int i = 15; i >= 0; i--) sq.push_back(w[k][i]);
    r = longRem(w);
    if (corrupt) r = r ^ 12'h004;
    for (int i = 11; i >= 0; i--) sq.push_back(r[i]);
  endtask

  task automatic sendSector(input int upto);
    for (int i = 0; i < sq.size() && i < upto; i++) sendBit(sq[i]);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [15:0] tw [NW];
    int d0;
    repeat (3) @(negedge clk);
    check(readGate == 0 && wordValid == 0 && addrMismatch == 0 && crcError == 0 &&
          lostData == 0 && sectorDone == 0 && checkStatus == 0, "R1 reset state",
          {readGate, wordValid, addrMismatch, crcError, lostData, sectorDone}, 0);
    rstN = 1'b1;
    expAddr = 24'hA5_3C71;

    // R2: mark ignored while enable is low
    buildSector(24'hA5_3C71, 16'h1234, 16'hBEEF, 16'h0F0F, 1'b0);
    pulseMark();
    sendSector(20);
    check(readGate == 0, "R2 mark ignored with enable low", readGate, 0);
    check(rxQ.size() == 0, "R2 no words with enable low", rxQ.size(), 0);

    // good sector with stray bits (R3, R5, R6, R8, R9)
    enable = 1'b1;
    d0 = doneCnt;
    pulseMark();
    sendSector(1000);
    tw[0] = 16'h1234; tw[1] = 16'hBEEF; tw[2] = 16'h0F0F;
    check(doneCnt == d0 + 1, "R9 one done pulse", doneCnt - d0, 1);
    check(rxQ.size() == 3, "R5 word count past stray sync bits", rxQ.size(), 3);
    if (rxQ.size() == 3) begin
      check(rxQ[0] == 16'h1234, "R6 word0 msb first", rxQ[0], 16'h1234);
      check(rxQ[2] == 16'h0F0F, "R6 word2", rxQ[2], 16'h0F0F);
    end
    check(checkStatus == longRem(tw), "R8 captured checkword", checkStatus, longRem(tw));
    check(readGate == 0, "R9 gate low after sector", readGate, 0);
    rxQ.delete();

    // corrupted checkword
    buildSector(24'hA5_3C71, 16'h0000, 16'hFFFF, 16'h8001, 1'b1);
    d0 = doneCnt;
    pulseMark();
    sendSector(1000);
    check(crcError == 1, "R9 checkword error flagged", crcError, 1);
    check(doneCnt == d0, "R9 no done on error", doneCnt - d0, 0);
    rxQ.delete();

    // header mismatch in lower half
    buildSector(24'hA5_3C70, 16'h1111, 16'h2222, 16'h3333, 1'b0);
    d0 = doneCnt;
    pulseMark();
    sendSector(1000);
    check(addrMismatch == 1, "R4 mismatch flagged", addrMismatch, 1);
    check(rxQ.size() == 0, "R4 no words after mismatch", rxQ.size(), 0);
    check(readGate == 0, "R4 gate low after mismatch", readGate, 0);
    check(doneCnt == d0, "R4 no done", doneCnt - d0, 0);

    // lost data: consumer holds off
    autoTake = 1'b0;
    buildSector(24'hA5_3C71, 16'hCAFE, 16'h5A5A, 16'h7777, 1'b0);
    d0 = doneCnt;
    pulseMark();
    check(addrMismatch == 0, "R2 mark clears mismatch", addrMismatch, 0);
    sendSector(1000);
    check(lostData == 1, "R7 lost data flagged", lostData, 1);
    check(doneCnt == d0, "R7 done suppressed", doneCnt - d0, 0);
    autoTake = 1'b1;
    repeat (10) @(negedge clk);
    check(rxQ.size() == 2, "R7 two words survive", rxQ.size(), 2);
    if (rxQ.size() == 2)
      check(rxQ[1] == 16'h5A5A, "R7 second word kept", rxQ[1], 16'h5A5A);
    rxQ.delete();

    // mid-sector restart
    buildSector(24'hA5_3C71, 16'h4321, 16'h8765, 16'hCBA9, 1'b0);
    d0 = doneCnt;
    pulseMark();
    sendSector(30);
    pulseMark();
    check(lostData == 0, "R10 mark clears lost data", lostData, 0);
    sendSector(1000);
    check(doneCnt == d0 + 1, "R10 restarted sector completes", doneCnt - d0, 1);
    check(rxQ.size() == 3, "R10 word count", rxQ.size(), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule